// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block holds the interrupt status of a CAN controller. It watches the transmit and receive error counters and raises a flag when a counter first crosses one of three levels: 96 for the warning states, 128 for the error-passive state and 256 for bus-off. Event strobes from the protocol engine mark a sent overload frame and the end of reset processing. Per-mailbox pending vectors and interrupt masks drive two further flags, one for received messages and one for received remote requests. All eight flags are sticky. A single interrupt request output is raised whenever any flag is set and its enable input is high.

Software sees the flags in the upper byte of one 16-bit register on a minimal select/write bus. Writing 1 to a bit clears the error-state, overload and reset-complete flags. The two mailbox flags ignore writes. They fall only when no mailbox with its interrupt enabled has a pending bit left. The protocol engine, the counter update rules and the mailbox store sit outside the block and appear as inputs.

Top module: `can_irq_flags`

## Requirements
- R1: After reset, bus_rdata reads 16'h0100: the reset-complete flag (bit 8) is 1 and the other seven flags are 0.
- R2: A write with bus_sel=1 and bus_wr=1 clears, on the next clock, each of bits 15 (overload), 14 (bus-off), 13 (receive warning), 12 (transmit warning), 11 (error passive) and 8 (reset complete) whose write-data bit is 1. Bits written 0 keep their value.
- R3: A one-cycle ovl_sent pulse sets bit 15 on the next clock.
- R4: Bit 14 sets on the clock after tx_err_cnt goes from below 256 to 256 or more.
- R5: Bit 12 sets when tx_err_cnt goes from below 96 to 96 or more. Bit 13 sets when rx_err_cnt makes the same crossing. A count of 95 sets neither.
- R6: Bit 11 sets when the condition "tx_err_cnt >= 128 or rx_err_cnt >= 128" goes from false to true.
- R7: If software clears a threshold flag while its condition still holds, the flag stays 0 until the condition goes false and then true again.
- R8: Bit 9 (message received) sets on the clock after rx_store=1 names, through rx_slot, a mailbox whose mb_mask bit is 0, for both data and remote frames. Writes to bit 9 have no effect. The bit clears on the next clock once (rx_pend & ~mb_mask) is all zero.
- R9: Bit 10 (remote request) sets on the clock after rx_store=1 with rx_remote=1 names a mailbox whose mb_mask bit is 0. It clears once (rr_pend & ~mb_mask) is all zero.
- R10: A store into a mailbox whose mb_mask bit is 1 sets neither bit 9 nor bit 10.
- R11: A one-cycle rst_done pulse sets bit 8 on the next clock.
- R12: When a set event and a write-1 clear reach the same flag in the same cycle, the flag is 1 afterwards.
- R13: irq equals the OR over i of flag bit (8+i) AND flag_en[i].
- R14: bus_rdata[7:0] always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_cnt | input | CNT_W | Transmit error counter value |
| rx_err_cnt | input | CNT_W | Receive error counter value |
| ovl_sent | input | 1 | Pulse: overload frame transmitted |
| rst_done | input | 1 | Pulse: reset processing finished |
| rx_store | input | 1 | Pulse: a received frame was stored in a mailbox |
| rx_remote | input | 1 | The stored frame was a remote frame |
| rx_slot | input | log2(N_MB) | Index of the mailbox written |
| rx_pend | input | N_MB | Receive-pending bit per mailbox |
| rr_pend | input | N_MB | Remote-request-pending bit per mailbox |
| mb_mask | input | N_MB | Per-mailbox interrupt mask, 1 = masked |
| flag_en | input | 8 | Per-flag interrupt enable, bit i for register bit 8+i |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Flag register read value |
| irq | output | 1 | Interrupt request |

## Verification
The checker properties take ovl_sent, rst_done and rx_store to be one-cycle strobes sampled at the clock. They also take the mailbox vectors to be consistent: the pending bit of a stored mailbox is high in the same cycle as its store. Otherwise the clear rule would take an unmasked flag down again at once. The stimulus keeps every strobe one vector long and raises the pending bit in the same vector as its store. Counter values change only between vectors, so each threshold crossing is seen as one clean edge.

// File: rtl/can_irq_pkg.sv
// Package: shared constants of the CAN interrupt flag register.
// Assumes flags occupy the upper byte of a 16-bit register.
package can_irq_pkg;
    localparam int FLAG_N   = 8;
    localparam int REG_W    = 16;
    localparam int FLAG_LSB = REG_W - FLAG_N;

    // Flag positions inside the flag byte (register bit = FLAG_LSB + index)
    localparam int F_RST  = 0;
    localparam int F_RMSG = 1;
    localparam int F_RREQ = 2;
    localparam int F_EPAS = 3;
    localparam int F_TXW  = 4;
    localparam int F_RXW  = 5;
    localparam int F_BOFF = 6;
    localparam int F_OVL  = 7;

    // Flags that software may clear by writing 1
    localparam logic [FLAG_N-1:0] SW_CLR_MASK = 8'b1111_1001;
    // Flag values after reset
    localparam logic [FLAG_N-1:0] RESET_VAL   = 8'b0000_0001;

    // Error counter levels
    localparam int WARN_LVL    = 96;
    localparam int PASSIVE_LVL = 128;
    localparam int BUSOFF_LVL  = 256;
endpackage

// File: rtl/can_lvl_edge.sv
// Module: can_lvl_edge
// Detects the cycle in which an error counter (or, with DUAL=1, either of
// two counters) first reaches LEVEL. Emits a one-cycle pulse on that rising
// edge of the condition. Assumes CNT_W is wide enough to hold LEVEL.
module can_lvl_edge #(
    parameter int CNT_W = 9,
    parameter int LEVEL = 96,
    parameter bit DUAL  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    output logic             rise
);
    localparam logic [CNT_W-1:0] LVL = CNT_W'(LEVEL);

    logic cond;
    logic cond_q;

    generate
        if (DUAL) begin : g_dual
            // Condition holds when either counter is at or above the level
            always_comb cond = (cnt_a >= LVL) || (cnt_b >= LVL);
        end else begin : g_single
            logic unused_b;
            assign unused_b = ^cnt_b;
            // Condition holds when the single counter is at or above the level
            always_comb cond = (cnt_a >= LVL);
        end
    endgenerate

    // Remember last cycle's condition for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    // Pulse only on the false-to-true transition
    always_comb rise = cond && !cond_q;
endmodule

// File: rtl/can_mbox_track.sv
// Module: can_mbox_track
// Qualifies a mailbox store against the interrupt mask. It also reports when
// no unmasked mailbox has a pending bit left. Assumes rx_slot < N_MB.
module can_mbox_track #(
    parameter int N_MB = 16,
    localparam int SLOT_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
    input  logic              store,
    input  logic [SLOT_W-1:0] slot,
    input  logic [N_MB-1:0]   pend,
    input  logic [N_MB-1:0]   mask,
    output logic              hit,
    output logic              idle
);
    logic [N_MB-1:0] live;

    // A store counts only if the target mailbox is not masked
    always_comb hit = store && !mask[slot];

    // Pending bits that belong to mailboxes with interrupts enabled
    always_comb live = pend & ~mask;

    // Idle when no enabled mailbox is still pending
    always_comb idle = (live == '0);
endmodule

// File: rtl/can_flag_cell.sv
// Module: can_flag_cell
// One sticky interrupt flag. A set event has priority over any clear.
// A software clear acts only when SW_CLR=1. A hardware clear acts only when
// HW_CLR=1. RST_VAL is the value loaded by reset.
module can_flag_cell #(
    parameter bit RST_VAL = 1'b0,
    parameter bit SW_CLR  = 1'b1,
    parameter bit HW_CLR  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic sw_clr,
    input  logic hw_clr,
    output logic q
);
    logic clr;

    generate
        if (SW_CLR && HW_CLR) begin : g_both
            // Either source may clear
            always_comb clr = sw_clr || hw_clr;
        end else if (SW_CLR) begin : g_sw
            logic unused_hw;
            assign unused_hw = hw_clr;
            // Only the software write clears
            always_comb clr = sw_clr;
        end else if (HW_CLR) begin : g_hw
            logic unused_sw;
            assign unused_sw = sw_clr;
            // Only the hardware condition clears
            always_comb clr = hw_clr;
        end else begin : g_none
            logic unused_cl;
            assign unused_cl = sw_clr ^ hw_clr;
            // Flag never clears except by reset
            always_comb clr = 1'b0;
        end
    endgenerate

    // Sticky flag update with set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/can_irq_flags.sv
// Module: can_irq_flags (top)
// CAN controller interrupt flag register: eight sticky flags from error
// counter levels, engine strobes and mailbox vectors, read on bus bits 15:8.
// Assumes strobes last one cycle and that mailbox pending bits rise together
// with their store.
module can_irq_flags #(
    parameter int CNT_W = 9,
    parameter int N_MB  = 16,
    localparam int SLOT_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_err_cnt,
    input  logic [CNT_W-1:0]  rx_err_cnt,
    input  logic              ovl_sent,
    input  logic              rst_done,
    input  logic              rx_store,
    input  logic              rx_remote,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [N_MB-1:0]   rx_pend,
    input  logic [N_MB-1:0]   rr_pend,
    input  logic [N_MB-1:0]   mb_mask,
    input  logic [7:0]        flag_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq
);
    import can_irq_pkg::*;

    logic [FLAG_N-1:0] set_v;
    logic [FLAG_N-1:0] swclr_v;
    logic [FLAG_N-1:0] hwclr_v;
    logic [FLAG_N-1:0] flags;
    logic              wr_en;
    logic              msg_hit, msg_idle;
    logic              rrq_hit, rrq_idle;
    logic              txw_rise, rxw_rise, epas_rise, boff_rise;
    logic              unused_lo;

    assign unused_lo = ^bus_wdata[FLAG_LSB-1:0];

    // Register write qualifier
    always_comb wr_en = bus_sel && bus_wr;

    // Threshold edge detectors for the error-state flags
    can_lvl_edge #(.CNT_W(CNT_W), .LEVEL(WARN_LVL), .DUAL(1'b0)) u_txw (
        .clk(clk), .rst_n(rst_n), .cnt_a(tx_err_cnt), .cnt_b(rx_err_cnt),
        .rise(txw_rise));
    can_lvl_edge #(.CNT_W(CNT_W), .LEVEL(WARN_LVL), .DUAL(1'b0)) u_rxw (
        .clk(clk), .rst_n(rst_n), .cnt_a(rx_err_cnt), .cnt_b(tx_err_cnt),
        .rise(rxw_rise));
    can_lvl_edge #(.CNT_W(CNT_W), .LEVEL(PASSIVE_LVL), .DUAL(1'b1)) u_epas (
        .clk(clk), .rst_n(rst_n), .cnt_a(tx_err_cnt), .cnt_b(rx_err_cnt),
        .rise(epas_rise));
    can_lvl_edge #(.CNT_W(CNT_W), .LEVEL(BUSOFF_LVL), .DUAL(1'b0)) u_boff (
        .clk(clk), .rst_n(rst_n), .cnt_a(tx_err_cnt), .cnt_b(rx_err_cnt),
        .rise(boff_rise));

    // Mailbox trackers for message-received and remote-request flags
    can_mbox_track #(.N_MB(N_MB)) u_msg (
        .store(rx_store), .slot(rx_slot), .pend(rx_pend), .mask(mb_mask),
        .hit(msg_hit), .idle(msg_idle));
    can_mbox_track #(.N_MB(N_MB)) u_rrq (
        .store(rx_store && rx_remote), .slot(rx_slot), .pend(rr_pend),
        .mask(mb_mask), .hit(rrq_hit), .idle(rrq_idle));

    // Gather the set events by flag index
    always_comb begin
        set_v         = '0;
        set_v[F_RST]  = rst_done;
        set_v[F_RMSG] = msg_hit;
        set_v[F_RREQ] = rrq_hit;
        set_v[F_EPAS] = epas_rise;
        set_v[F_TXW]  = txw_rise;
        set_v[F_RXW]  = rxw_rise;
        set_v[F_BOFF] = boff_rise;
        set_v[F_OVL]  = ovl_sent;
    end

    // Gather the hardware clear conditions (mailbox flags only)
    always_comb begin
        hwclr_v         = '0;
        hwclr_v[F_RMSG] = msg_idle;
        hwclr_v[F_RREQ] = rrq_idle;
    end

    // Software write-1 clears, one per flag byte bit
    always_comb swclr_v = wr_en ? bus_wdata[REG_W-1:FLAG_LSB] : '0;

    // One flag cell per bit; the variant follows the package masks
    generate
        for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
            can_flag_cell #(
                .RST_VAL(RESET_VAL[i]),
                .SW_CLR (SW_CLR_MASK[i]),
                .HW_CLR (!SW_CLR_MASK[i])
            ) u_cell (
                .clk(clk), .rst_n(rst_n), .set(set_v[i]),
                .sw_clr(swclr_v[i]), .hw_clr(hwclr_v[i]), .q(flags[i]));
        end
    endgenerate

    // Register read view: flags in the upper byte, zeros below
    always_comb bus_rdata = {flags, {FLAG_LSB{1'b0}}};

    // Interrupt request from enabled flags
    always_comb irq = |(flags & flag_en);
endmodule

// File: rtl/can_irq_flags_chk.sv
// Module: can_irq_flags_chk
// Property checker for can_irq_flags, attached by bind. It watches ports only.
// Assumes one-cycle strobes and consistent mailbox vectors.
module can_irq_flags_chk #(
    parameter int CNT_W = 9,
    parameter int N_MB  = 16,
    localparam int SLOT_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  tx_err_cnt,
    input logic [CNT_W-1:0]  rx_err_cnt,
    input logic              ovl_sent,
    input logic              rst_done,
    input logic              rx_store,
    input logic              rx_remote,
    input logic [SLOT_W-1:0] rx_slot,
    input logic [N_MB-1:0]   rx_pend,
    input logic [N_MB-1:0]   rr_pend,
    input logic [N_MB-1:0]   mb_mask,
    input logic [7:0]        flag_en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              irq
);
    logic wr1;
    always_comb wr1 = bus_sel && bus_wr;

    AST_RST_VALUE: assert property (@(posedge clk)
        !rst_n |=> bus_rdata == 16'h0100); // R1

    AST_W1C_OVL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && bus_wdata[15] && !ovl_sent) |=> !bus_rdata[15]); // R2

    AST_OVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_sent && !(wr1 && bus_wdata[15])) |=> $stable(bus_rdata[15])); // R2

    AST_OVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_sent |=> bus_rdata[15]); // R3

    AST_BUSOFF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_cnt >= CNT_W'(256) && $past(tx_err_cnt) < CNT_W'(256))
        |=> bus_rdata[14]); // R4

    AST_TXWARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_err_cnt >= CNT_W'(96)) |=> bus_rdata[12]); // R5

    AST_RXWARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_err_cnt >= CNT_W'(96)) |=> bus_rdata[13]); // R5

    AST_PASSIVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_err_cnt >= CNT_W'(128) || rx_err_cnt >= CNT_W'(128))
        |=> bus_rdata[11]); // R6

    AST_TXWARN_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_cnt >= CNT_W'(96) && $past(tx_err_cnt) >= CNT_W'(96) && !bus_rdata[12])
        |=> !bus_rdata[12]); // R7

    AST_MSG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_pend & ~mb_mask) == '0 && !(rx_store && !mb_mask[rx_slot]))
        |=> !bus_rdata[9]); // R8

    AST_MSG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[9] && wr1 && bus_wdata[9] && (rx_pend & ~mb_mask) != '0)
        |=> bus_rdata[9]); // R8

    AST_RREQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store && rx_remote && !mb_mask[rx_slot]) |=> bus_rdata[10]); // R9

    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store && mb_mask[rx_slot] && !bus_rdata[9] && !bus_rdata[10])
        |=> (!bus_rdata[9] && !bus_rdata[10])); // R10

    AST_RST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> bus_rdata[8]); // R11

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done && wr1 && bus_wdata[8]) |=> bus_rdata[8]); // R12

    AST_IRQ_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(bus_rdata[15:8] & flag_en)); // R13

    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:0] == 8'h00); // R14

    logic unused_rr;
    assign unused_rr = ^rr_pend;
endmodule

bind can_irq_flags can_irq_flags_chk #(.CNT_W(CNT_W), .N_MB(N_MB)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .ovl_sent(ovl_sent), .rst_done(rst_done), .rx_store(rx_store),
    .rx_remote(rx_remote), .rx_slot(rx_slot), .rx_pend(rx_pend),
    .rr_pend(rr_pend), .mb_mask(mb_mask), .flag_en(flag_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

// File: tb/tb_can_irq_flags.sv
// Bench for can_irq_flags: a vector table walked by one loop, then directed
// tests for threshold boundaries, set-versus-clear priority and reset flag.
module tb_can_irq_flags;
    localparam int CNT_W = 9;
    localparam int N_MB  = 16;

    typedef struct packed {
        logic [8:0]  tec;
        logic [8:0]  rec;
        logic        ovl;
        logic        rdone;
        logic        store;
        logic        remote;
        logic [3:0]  slot;
        logic [15:0] rxp;
        logic [15:0] rrp;
        logic [15:0] mask;
        logic        wr;
        logic [7:0]  wbyte;
        logic [7:0]  en;
        logic [7:0]  expf;
        logic        expirq;
    } vec_t;

    // Flag byte: b7 ovl, b6 bus-off, b5 rx warn, b4 tx warn, b3 passive,
    // b2 remote req, b1 msg rx, b0 reset done
    localparam int NV = 22;
    localparam vec_t VEC [0:NV-1] = '{
        '{9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h01,1'b1}, // R1 idle
        '{9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b1,8'h01,8'hFF,8'h00,1'b0}, // R2 clear reset flag
        '{9'd0,   9'd0,   1'b1,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h80,1'b1}, // R3 overload
        '{9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b1,8'h00,8'hFF,8'h80,1'b1}, // R2 write zero
        '{9'd100, 9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h90,1'b1}, // R5 tx warn
        '{9'd130, 9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h98,1'b1}, // R6 passive tx
        '{9'd260, 9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'hD8,1'b1}, // R4 bus-off
        '{9'd260, 9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b1,8'hFF,8'hFF,8'h00,1'b0}, // R2 clear all
        '{9'd260, 9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h00,1'b0}, // R7 stays clear
        '{9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h00,1'b0}, // R7 condition falls
        '{9'd0,   9'd100, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h20,1'b1}, // R5 rx warn
        '{9'd0,   9'd140, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h28,1'b1}, // R6 passive rx
        '{9'd0,   9'd140, 1'b0,1'b0,1'b1,1'b0,4'd3,16'h0008,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h2A,1'b1}, // R8 data store
        '{9'd0,   9'd140, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0008,16'h0000,16'h0000,1'b1,8'h02,8'hFF,8'h2A,1'b1}, // R8 write ignored
        '{9'd0,   9'd140, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,8'h00,8'hFF,8'h28,1'b1}, // R8 pend cleared
        '{9'd0,   9'd140, 1'b0,1'b0,1'b1,1'b0,4'd4,16'h0010,16'h0000,16'h0010,1'b0,8'h00,8'hFF,8'h28,1'b1}, // R10 masked store
        '{9'd0,   9'd140, 1'b0,1'b0,1'b1,1'b1,4'd2,16'h0014,16'h0004,16'h0010,1'b0,8'h00,8'hFF,8'h2E,1'b1}, // R9 remote store
        '{9'd0,   9'd140, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0014,16'h0000,16'h0010,1'b0,8'h00,8'hFF,8'h2A,1'b1}, // R9 rr pend cleared
        '{9'd0,   9'd140, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0010,16'h0000,16'h0010,1'b0,8'h00,8'hFF,8'h28,1'b1}, // R8 only masked pending
        '{9'd0,   9'd140, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0010,16'h0000,16'h0010,1'b0,8'h00,8'h00,8'h28,1'b0}, // R13 all disabled
        '{9'd0,   9'd140, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0010,16'h0000,16'h0010,1'b0,8'h00,8'h08,8'h28,1'b1}, // R13 passive enabled
        '{9'd0,   9'd140, 1'b0,1'b0,1'b0,1'b0,4'd0,16'h0010,16'h0000,16'h0010,1'b0,8'h00,8'h10,8'h28,1'b0}  // R13 other enabled
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] tx_err_cnt = '0;
    logic [CNT_W-1:0] rx_err_cnt = '0;
    logic             ovl_sent = 1'b0;
    logic             rst_done = 1'b0;
    logic             rx_store = 1'b0;
    logic             rx_remote = 1'b0;
    logic [3:0]       rx_slot = '0;
    logic [N_MB-1:0]  rx_pend = '0;
    logic [N_MB-1:0]  rr_pend = '0;
    logic [N_MB-1:0]  mb_mask = '0;
    logic [7:0]       flag_en = 8'hFF;
    logic             bus_sel = 1'b0;
    logic             bus_wr = 1'b0;
    logic [15:0]      bus_wdata = '0;
    logic [15:0]      bus_rdata;
    logic             irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    can_irq_flags #(.CNT_W(CNT_W), .N_MB(N_MB)) dut (
        .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .ovl_sent(ovl_sent), .rst_done(rst_done), .rx_store(rx_store),
        .rx_remote(rx_remote), .rx_slot(rx_slot), .rx_pend(rx_pend),
        .rr_pend(rr_pend), .mb_mask(mb_mask), .flag_en(flag_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq));

    task automatic check(input string tag, input logic [7:0] expf, input logic expirq);
        n_chk++;
        if (bus_rdata !== {expf, 8'h00}) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected=%h", tag, bus_rdata, {expf, 8'h00});
        end
        n_chk++;
        if (irq !== expirq) begin
            n_fail++;
            $display("FAIL %s R13: irq=%b expected=%b", tag, irq, expirq);
        end
    endtask

    // Drive one vector at a falling edge, check at the next falling edge
    task automatic run_vec(input vec_t v, input string tag);
        tx_err_cnt = v.tec;
        rx_err_cnt = v.rec;
        ovl_sent   = v.ovl;
        rst_done   = v.rdone;
        rx_store   = v.store;
        rx_remote  = v.remote;
        rx_slot    = v.slot;
        rx_pend    = v.rxp;
        rr_pend    = v.rrp;
        mb_mask    = v.mask;
        bus_sel    = v.wr;
        bus_wr     = v.wr;
        bus_wdata  = {v.wbyte, 8'h00};
        flag_en    = v.en;
        @(negedge clk);
        check(tag, v.expf, v.expirq);
    endtask

    function automatic vec_t mk(input logic [8:0] tec, input logic [8:0] rec,
                                input logic ovl, input logic rdone, input logic wr,
                                input logic [7:0] wbyte, input logic [7:0] expf);
        vec_t v;
        v = '0;
        v.tec = tec;  v.rec = rec;  v.ovl = ovl;  v.rdone = rdone;
        v.wr = wr;  v.wbyte = wbyte;  v.en = 8'hFF;
        v.expf = expf;  v.expirq = |expf;
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state", 8'h01, 1'b1);            // R14 low byte zero too

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], $sformatf("vector %0d", i));
        end

        // Directed: clear everything, then warning/passive/bus-off boundaries
        run_vec(mk(9'd0,   9'd0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00), "R2 clear all");
        run_vec(mk(9'd95,  9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00), "R5 tec 95 below");
        run_vec(mk(9'd96,  9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10), "R5 tec 96");
        run_vec(mk(9'd127, 9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10), "R6 tec 127 below");
        run_vec(mk(9'd128, 9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h18), "R6 tec 128");
        run_vec(mk(9'd255, 9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h18), "R4 tec 255 below");
        run_vec(mk(9'd256, 9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h58), "R4 tec 256");
        // Set versus clear in the same cycle
        run_vec(mk(9'd256, 9'd0, 1'b1, 1'b0, 1'b1, 8'h80, 8'hD8), "R12 ovl set wins");
        run_vec(mk(9'd256, 9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hD8), "R3 ovl held");
        run_vec(mk(9'd256, 9'd0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h58), "R2 ovl cleared");
        run_vec(mk(9'd256, 9'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h59), "R11 reset done");
        run_vec(mk(9'd256, 9'd0, 1'b0, 1'b1, 1'b1, 8'h01, 8'h59), "R12 reset set wins");
        run_vec(mk(9'd256, 9'd0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h58), "R2 reset flag cleared");
        // Re-arm after the condition falls and rises again
        run_vec(mk(9'd256, 9'd0, 1'b0, 1'b0, 1'b1, 8'h10, 8'h48), "R7 tx warn cleared");
        run_vec(mk(9'd50,  9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h48), "R7 below level");
        run_vec(mk(9'd97,  9'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h58), "R7 rises again");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule